// File: doc/BRIEF.md
# Edge-Selectable Auxiliary Event Counter

A 16-bit up/down counter that advances on chosen transitions of one of two sources. One source is an external count pin. It passes through a synchroniser and a stable-level filter before its edges are taken. The other source is a toggle latch kept inside the block. The latch flips each time a companion timer reports an overflow or underflow. Software may also write the latch directly, and such a write never counts.

A 3-bit mode field chooses the source and which edges count. A run bit gates counting. The direction comes from a software bit, optionally XORed with a synchronised external direction pin. Software can load the count at any time. Each wrap-around raises a one-cycle interrupt request.

Top module: `aux_event_counter`

## Requirements
- R1: Mode encoding is bit 2 = source (0 count pin, 1 toggle latch) and bits 1:0 = edge (01 rising, 10 falling, 11 both). Bits 1:0 = 00 disables counting whatever bit 2 is.
- R2: The count pin passes a two-flop synchroniser. A new level is accepted only after the synchronised value has held it for 2 consecutive clocks, so a pin level held for a single clock is ignored. A counted pin edge changes count_o 4 clocks after the first rising clock edge that samples the new level.
- R3: A pulse on tgl_hw_i inverts the toggle latch at that clock edge. When the edge type matches the selected edge, the count moves one clock later. A write through tgl_wr_i sets the latch to tgl_wr_val_i and never produces a count. A write in the same cycle as tgl_hw_i wins, and the toggle is dropped.
- R4: While run_i is 0, no event changes the count. Events that occur in that time are lost.
- R5: Direction is ud_i XOR (ext_dir_en_i AND the synchronised dir_pin_i), where 1 means count down and 0 means count up. With ext_dir_en_i at 0, ud_i alone decides.
- R6: load_i copies load_val_i into the count at the next clock edge, and takes priority over a count event in the same cycle.
- R7: Counting up from 0xFFFF gives 0x0000, and counting down from 0x0000 gives 0xFFFF. Each wrap asserts irq_o for exactly one clock, in the same cycle the wrapped value appears. irq_o is 0 otherwise.
- R8: While rst_ni is low, count_o, irq_o and tgl_latch_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Source and edge select |
| run_i | input | 1 | Counting enable |
| ud_i | input | 1 | Software direction, 1 = down |
| ext_dir_en_i | input | 1 | Enables the external direction pin |
| cnt_pin_i | input | 1 | External count pin, asynchronous |
| dir_pin_i | input | 1 | External direction pin, asynchronous |
| tgl_hw_i | input | 1 | Companion timer overflow/underflow pulse |
| tgl_wr_i | input | 1 | Software write strobe for the toggle latch |
| tgl_wr_val_i | input | 1 | Value written to the toggle latch |
| load_i | input | 1 | Software count load strobe |
| load_val_i | input | 16 | Value to load |
| tgl_latch_o | output | 1 | Current toggle latch level |
| count_o | output | 16 | Counter value |
| irq_o | output | 1 | Wrap interrupt pulse |

## Verification
A count from the pin appears 4 clocks after the first edge that samples the new level. A toggle pulse shows on the latch at once and on the count one clock later. A load, and the interrupt of a wrap, appear on the edge that samples them. The bench keeps these latencies by driving all inputs on the falling clock edge and stepping a behavioural model on each rising edge. It then compares count, interrupt and latch with the model at every falling edge. Explicit end-of-phase checks confirm totals that are worked out by hand from the requirements, including glitch rejection and the silent software write.

// File: rtl/aux_evcnt_pkg.sv
package aux_evcnt_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic      src_latch;
    edge_sel_e edge_sel;
  } mode_t;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/aux_evcnt_sync.sv
module aux_evcnt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/aux_evcnt_filter.sv
module aux_evcnt_filter
  import aux_evcnt_pkg::*;
#(
  parameter int HOLD = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  lvl_i,
  output edge_t edge_o
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

  logic [CW-1:0] run_q;
  logic          lvl_q, prev_q;

  // a new level must be seen HOLD clocks in a row before it is taken
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      lvl_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= lvl_q;
      if (lvl_i != lvl_q) begin
        if (run_q == CW'(HOLD - 1)) begin
          lvl_q <= lvl_i;
          run_q <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign edge_o.rise = lvl_q & ~prev_q;
  assign edge_o.fall = ~lvl_q & prev_q;

  assert_filter_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != $past(lvl_q)) |-> ($past(lvl_i) == lvl_q));
endmodule

// File: rtl/aux_evcnt_latch.sv
module aux_evcnt_latch
  import aux_evcnt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  hw_tgl_i,
  input  logic  wr_i,
  input  logic  wr_val_i,
  output logic  latch_o,
  output edge_t edge_o
);
  logic  latch_q;
  edge_t edge_q;

  // only hardware toggles produce edge pulses; software writes are silent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
      edge_q  <= '0;
    end else if (wr_i) begin
      latch_q <= wr_val_i;
      edge_q  <= '0;
    end else if (hw_tgl_i) begin
      latch_q     <= ~latch_q;
      edge_q.rise <= ~latch_q;
      edge_q.fall <= latch_q;
    end else begin
      edge_q <= '0;
    end
  end

  assign latch_o = latch_q;
  assign edge_o  = edge_q;

  assert_sw_write_silent_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (edge_o == '0 && latch_o == $past(wr_val_i)));
  assert_hw_toggle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_tgl_i && !wr_i) |=> (latch_o != $past(latch_o)));
endmodule

// File: rtl/aux_evcnt_core.sv
module aux_evcnt_core #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         evt_i,
  input  logic         down_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] count_o,
  output logic         irq_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] count_q;
  logic         irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      irq_q   <= 1'b0;
    end else if (load_i) begin
      count_q <= load_val_i;
      irq_q   <= 1'b0;
    end else if (evt_i) begin
      if (down_i) begin
        count_q <= count_q - 1'b1;
        irq_q   <= (count_q == '0);
      end else begin
        count_q <= count_q + 1'b1;
        irq_q   <= (count_q == CNT_MAX);
      end
    end else begin
      irq_q <= 1'b0;
    end
  end

  assign count_o = count_q;
  assign irq_o   = irq_q;

  assert_load_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (count_q == $past(load_val_i)));
  assert_irq_on_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> ((count_q == '0 && $past(count_q) == CNT_MAX) ||
               (count_q == CNT_MAX && $past(count_q) == '0)));
  assert_irq_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> (!irq_q || $past(evt_i)));
  assert_up_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !load_i && !down_i) |=> (count_q == W'($past(count_q) + 1'b1)));
  assert_down_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !load_i && down_i) |=> (count_q == W'($past(count_q) - 1'b1)));
endmodule

// File: rtl/aux_event_counter.sv
module aux_event_counter
  import aux_evcnt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_i,
  input  logic             run_i,
  input  logic             ud_i,
  input  logic             ext_dir_en_i,
  input  logic             cnt_pin_i,
  input  logic             dir_pin_i,
  input  logic             tgl_hw_i,
  input  logic             tgl_wr_i,
  input  logic             tgl_wr_val_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             tgl_latch_o,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  mode_t      mode;
  logic [1:0] pins_s;
  edge_t      pin_edge, lat_edge, src_edge;
  logic       hit, evt, down;

  assign mode = mode_t'(mode_i);

  aux_evcnt_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dir_pin_i, cnt_pin_i}),
    .q_o   (pins_s)
  );

  aux_evcnt_filter #(.HOLD(HOLD_CYC)) i_filter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pins_s[0]),
    .edge_o(pin_edge)
  );

  aux_evcnt_latch i_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hw_tgl_i(tgl_hw_i),
    .wr_i    (tgl_wr_i),
    .wr_val_i(tgl_wr_val_i),
    .latch_o (tgl_latch_o),
    .edge_o  (lat_edge)
  );

  assign src_edge = mode.src_latch ? lat_edge : pin_edge;

  always_comb begin
    unique case (mode.edge_sel)
      EDGE_RISE: hit = src_edge.rise;
      EDGE_FALL: hit = src_edge.fall;
      EDGE_BOTH: hit = src_edge.rise | src_edge.fall;
      default:   hit = 1'b0;
    endcase
  end

  assign evt  = run_i & hit;
  assign down = ud_i ^ (ext_dir_en_i & pins_s[1]);

  aux_evcnt_core #(.W(CNT_W)) i_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt),
    .down_i    (down),
    .load_i    (load_i),
    .load_val_i(load_val_i),
    .count_o   (count_o),
    .irq_o     (irq_o)
  );

  assert_mode_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1:0] == 2'b00 && !load_i) |=> $stable(count_o));
  assert_run_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(count_o));
  assert_no_irq_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt || load_i) |=> !irq_o);
endmodule

// File: tb/test_aux_event_counter.sv
module test_aux_event_counter;
  localparam int W    = 16;
  localparam int HOLD = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   mode = 3'b000;
  logic         run = 1'b0, ud = 1'b0, ext_en = 1'b0;
  logic         cnt_pin = 1'b0, dir_pin = 1'b0;
  logic         tgl_hw = 1'b0, tgl_wr = 1'b0, tgl_wr_val = 1'b0;
  logic         load = 1'b0;
  logic [W-1:0] load_val = '0;
  logic         tgl_latch;
  logic [W-1:0] count;
  logic         irq;

  int    n_chk = 0, n_err = 0, cyc = 0, irq_seen = 0;
  string cur_req = "R8";

  always #5ns clk = ~clk;

  aux_event_counter i_aux_event_counter (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .run_i(run), .ud_i(ud),
    .ext_dir_en_i(ext_en), .cnt_pin_i(cnt_pin), .dir_pin_i(dir_pin),
    .tgl_hw_i(tgl_hw), .tgl_wr_i(tgl_wr), .tgl_wr_val_i(tgl_wr_val),
    .load_i(load), .load_val_i(load_val), .tgl_latch_o(tgl_latch),
    .count_o(count), .irq_o(irq)
  );

  // behavioural reference model
  int p1, p2, d1, d2, flt, flt_prev, hold_n;
  int m_lat, m_rise, m_fall, m_cnt, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 = 0; p2 = 0; d1 = 0; d2 = 0; flt = 0; flt_prev = 0; hold_n = 0;
      m_lat = 0; m_rise = 0; m_fall = 0; m_cnt = 0; m_irq = 0;
    end else begin
      int r, f, ev, dn;
      if (mode[2]) begin r = m_rise; f = m_fall; end
      else begin r = (flt == 1 && flt_prev == 0); f = (flt == 0 && flt_prev == 1); end
      case (mode[1:0])
        2'b01:   ev = r;
        2'b10:   ev = f;
        2'b11:   ev = r | f;
        default: ev = 0;
      endcase
      ev = ev & run;
      dn = ud ^ (ext_en & d2);
      if (load) begin m_cnt = load_val; m_irq = 0; end
      else if (ev != 0) begin
        if (dn != 0) begin m_irq = (m_cnt == 0); m_cnt = (m_cnt + 65535) % 65536; end
        else         begin m_irq = (m_cnt == 65535); m_cnt = (m_cnt + 1) % 65536; end
      end else m_irq = 0;
      flt_prev = flt;
      if (p2 != flt) begin
        if (hold_n == HOLD - 1) begin flt = p2; hold_n = 0; end
        else hold_n++;
      end else hold_n = 0;
      p2 = p1; p1 = cnt_pin; d2 = d1; d1 = dir_pin;
      if (tgl_wr) begin m_lat = tgl_wr_val; m_rise = 0; m_fall = 0; end
      else if (tgl_hw) begin m_rise = (m_lat == 0); m_fall = m_lat; m_lat = 1 - m_lat; end
      else begin m_rise = 0; m_fall = 0; end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) irq_seen++;
      chk(cur_req, "count", int'(count), m_cnt);
      chk(cur_req, "irq", int'(irq), m_irq);
      chk(cur_req, "latch", int'(tgl_latch), m_lat);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_pulse(int hi, int lo);
    cnt_pin = 1'b1; step(hi);
    cnt_pin = 1'b0; step(lo);
  endtask

  task automatic hw_tgl();
    tgl_hw = 1'b1; step(1);
    tgl_hw = 1'b0; step(3);
  endtask

  task automatic sw_wr(logic v);
    tgl_wr = 1'b1; tgl_wr_val = v; step(1);
    tgl_wr = 1'b0; step(3);
  endtask

  initial begin
    step(3);
    chk("R8", "reset count", int'(count), 0);
    chk("R8", "reset irq", int'(irq), 0);
    chk("R8", "reset latch", int'(tgl_latch), 0);
    rst_n = 1'b1;
    step(2);

    cur_req = "R1"; run = 1'b1;
    mode = 3'b001; repeat (3) pin_pulse(4, 6);
    chk("R1", "rising total", int'(count), 3);
    mode = 3'b010; repeat (2) pin_pulse(4, 6);
    chk("R1", "falling total", int'(count), 5);
    mode = 3'b011; repeat (2) pin_pulse(4, 6);
    chk("R1", "both total", int'(count), 9);
    mode = 3'b000; repeat (2) pin_pulse(4, 6);
    mode = 3'b100; repeat (2) hw_tgl();
    chk("R1", "disabled codes", int'(count), 9);

    cur_req = "R2"; mode = 3'b011;
    repeat (3) pin_pulse(1, 6);
    chk("R2", "glitches ignored", int'(count), 9);
    pin_pulse(2, 6);
    chk("R2", "two-cycle pulse", int'(count), 11);

    cur_req = "R3"; mode = 3'b101;
    repeat (4) hw_tgl();
    chk("R3", "latch rising", int'(count), 13);
    mode = 3'b110; repeat (2) hw_tgl();
    chk("R3", "latch falling", int'(count), 14);
    mode = 3'b111; repeat (2) hw_tgl();
    chk("R3", "latch both", int'(count), 16);
    sw_wr(1'b1);
    chk("R3", "sw write latch", int'(tgl_latch), 1);
    chk("R3", "sw write silent", int'(count), 16);
    sw_wr(1'b0);
    chk("R3", "sw write clear silent", int'(count), 16);
    tgl_hw = 1'b1; tgl_wr = 1'b1; tgl_wr_val = 1'b1; step(1);
    tgl_hw = 1'b0; tgl_wr = 1'b0; step(3);
    chk("R3", "write beats toggle latch", int'(tgl_latch), 1);
    chk("R3", "write beats toggle count", int'(count), 16);
    sw_wr(1'b0);

    cur_req = "R4"; run = 1'b0; mode = 3'b011;
    repeat (2) pin_pulse(4, 6);
    hw_tgl(); sw_wr(1'b0);
    chk("R4", "run off", int'(count), 16);
    run = 1'b1;

    cur_req = "R5"; ud = 1'b1; mode = 3'b011;
    repeat (2) pin_pulse(4, 6);
    chk("R5", "down by ud", int'(count), 12);
    ext_en = 1'b1; dir_pin = 1'b1; step(4);
    repeat (2) pin_pulse(4, 6);
    chk("R5", "pin inverts to up", int'(count), 16);
    ud = 1'b0; pin_pulse(4, 6);
    chk("R5", "pin alone down", int'(count), 14);
    ext_en = 1'b0; pin_pulse(4, 6);
    chk("R5", "pin disabled up", int'(count), 16);
    dir_pin = 1'b0;

    cur_req = "R6"; mode = 3'b101; load_val = 16'h1234;
    tgl_hw = 1'b1; step(1);
    tgl_hw = 1'b0; load = 1'b1; step(1);
    load = 1'b0; step(3);
    chk("R6", "load beats event", int'(count), 'h1234);
    sw_wr(1'b0);

    cur_req = "R7"; load_val = 16'hFFFF; load = 1'b1; step(1); load = 1'b0;
    mode = 3'b011; irq_seen = 0;
    pin_pulse(4, 0); step(2);
    chk("R7", "up wrap count", int'(count), 0);
    chk("R7", "up wrap irq", irq_seen, 1);
    step(6);
    chk("R7", "after fall", int'(count), 1);
    ud = 1'b1; pin_pulse(4, 6);
    chk("R7", "down wrap count", int'(count), 'hFFFF);
    chk("R7", "irq total", irq_seen, 2);

    step(4);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule